// File: doc/BRIEF.md
# Bouncing LED Bar Sequencer

This block drives a row of LEDs with a bar of lit outputs that always starts at bit 0. The bar grows by one LED per visible frame until all LEDs are lit, then shrinks by one per frame until a single LED is lit, and repeats this without end. Every visible frame is followed by a single all-off blanking cycle, so the display strobes at half the clock rate.

A synchronous reset loads a fixed alternating pattern onto the LEDs. The first clock after reset blanks the LEDs, which gives a one-cycle strobe, and the bounce then starts from the one-LED bar. The stored bar length and the direction bit are brought out as ports so that the sequencing state can be observed from outside.

Top module: `led_bounce_bar`

## Requirements
- R1: A clock edge with `rst` high loads `led` with the alternating pattern 10101 (bits 0, 2 and 4 lit), `bar_len` with code 010 and `grow` with 0.
- R2: Reset wins over every other update. While `rst` stays high the R1 values are held, and reset asserted in the middle of the sequence restarts it from the R1 state.
- R3: On the first edge after reset is released, `led` becomes 00000. This is the one-cycle strobe.
- R4: After the strobe, blank cycles (all LEDs off) and visible cycles strictly alternate, so every second cycle shows 00000.
- R5: A visible frame is a contiguous run of lit LEDs starting at bit 0. The frames follow the order 00001, 00011, 00111, 01111, 11111, 01111, 00111, 00011 and then repeat.
- R6: `grow` becomes 0 on the frame that lights all five LEDs and 1 on the frame that lights a single LED. On all other frames it keeps its value.
- R7: `bar_len` holds the number of lit LEDs in the most recent visible frame, coded in binary (001 to 101). It changes only on visible cycles and stays stable across blank cycles.
- R8: The first visible frame after the strobe is 00001 and leaves `grow` at 1. The pattern then repeats every 16 clocks: 8 visible frames and 8 blanks.
- R9: Length codes outside 010 to 101 are handled as the bottom of the bounce. The next visible frame is 00011 with `grow` set to 1. In normal operation code 001 takes this path.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Active-high synchronous reset |
| led | output | 5 | Registered LED drive, bit 0 is the anchored end of the bar |
| grow | output | 1 | Direction bit: 1 while the bar is growing, 0 while it is shrinking |
| bar_len | output | 3 | Length of the last visible bar |

## Verification
The in-line properties assume only that `rst` is synchronous and sampled at the rising edge. Each property that describes normal sequencing is disabled while reset is high, so it may be asserted for any number of cycles at any phase. The bench drives `rst` only at falling edges, and it applies reset at each of the sixteen phases of the period as well as for several consecutive cycles. Between resets the block runs freely, so the properties see every reachable length and direction code, including the bottom-of-bounce code.

// File: rtl/led_bounce_pkg.sv
package led_bounce_pkg;
  // Width needed to hold a bar length of 0..n
  function automatic int len_width(input int n);
    return $clog2(n + 1);
  endfunction
endpackage

// File: rtl/led_bounce_phase.sv
module led_bounce_phase (
  input  logic clk,
  input  logic rst,
  output logic blank_q
);
  // blank_q = 1 means the coming edge produces a dark frame
  always_ff @(posedge clk) begin
    if (rst) blank_q <= 1'b1;
    else     blank_q <= ~blank_q;
  end
endmodule

// File: rtl/led_bounce_stepper.sv
module led_bounce_stepper #(
  parameter int LEDS  = 5,
  parameter int LEN_W = led_bounce_pkg::len_width(LEDS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             adv,
  output logic [LEN_W-1:0] len_q,
  output logic             dir_q,
  output logic [LEN_W-1:0] len_nxt
);
  localparam logic [LEN_W-1:0] LEN_MAX   = LEN_W'(LEDS);
  localparam logic [LEN_W-1:0] LEN_ONE   = LEN_W'(1);
  localparam logic [LEN_W-1:0] LEN_TWO   = LEN_W'(2);
  localparam logic [LEN_W-1:0] LEN_RESET = LEN_TWO;

  logic dir_nxt;

  always_comb begin
    if (len_q >= LEN_TWO && len_q <= LEN_MAX) begin
      if (len_q == LEN_MAX || !dir_q) len_nxt = len_q - LEN_ONE;
      else                            len_nxt = len_q + LEN_ONE;
      if (len_nxt == LEN_MAX)      dir_nxt = 1'b0;
      else if (len_nxt == LEN_ONE) dir_nxt = 1'b1;
      else                         dir_nxt = dir_q;
    end else begin
      // bottom / unused codes: step to a two-LED bar, growing
      len_nxt = LEN_TWO;
      dir_nxt = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      len_q <= LEN_RESET;
      dir_q <= 1'b0;
    end else if (adv) begin
      len_q <= len_nxt;
      dir_q <= dir_nxt;
    end
  end

  // R6: direction agrees with the ends of the bounce
  assert_dir_top_R6: assert property (@(posedge clk) disable iff (rst)
    (len_q == LEN_MAX) |-> !dir_q) else $error("dir not shrinking at top");
  assert_dir_bottom_R6: assert property (@(posedge clk) disable iff (rst)
    (len_q == LEN_ONE) |-> dir_q) else $error("dir not growing at bottom");
  // R7: length holds across blank cycles and stays in range
  assert_len_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !adv |=> $stable(len_q)) else $error("length moved on blank");
  assert_len_range_R7: assert property (@(posedge clk) disable iff (rst)
    adv |=> (len_q >= LEN_ONE && len_q <= LEN_MAX)) else $error("length out of range");
endmodule

// File: rtl/led_bounce_shaper.sv
module led_bounce_shaper #(
  parameter int LEDS  = 5,
  parameter int LEN_W = led_bounce_pkg::len_width(LEDS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             blank,
  input  logic [LEN_W-1:0] len_nxt,
  output logic [LEDS-1:0]  led_q
);
  logic [LEDS-1:0] bar;
  logic [LEDS-1:0] rst_pat;

  for (genvar i = 0; i < LEDS; i++) begin : g_lane
    assign bar[i]     = (LEN_W'(i) < len_nxt);
    assign rst_pat[i] = ((i % 2) == 0);
  end

  always_ff @(posedge clk) begin
    if (rst)        led_q <= rst_pat;
    else if (blank) led_q <= '0;
    else            led_q <= bar;
  end

  // R4: a blank phase always yields a dark frame
  assert_blank_dark_R4: assert property (@(posedge clk) disable iff (rst)
    blank |=> (led_q == '0)) else $error("blank frame not dark");
  // R5: visible frames are contiguous runs from bit 0
  assert_bar_shape_R5: assert property (@(posedge clk) disable iff (rst)
    !blank |=> (led_q[0] && ((led_q & (led_q + 1'b1)) == '0)))
    else $error("visible frame not an anchored bar");
endmodule

// File: rtl/led_bounce_bar.sv
module led_bounce_bar #(
  parameter int LEDS  = 5,
  parameter int LEN_W = led_bounce_pkg::len_width(LEDS)
) (
  input  logic             clk,
  input  logic             rst,
  output logic [LEDS-1:0]  led,
  output logic             grow,
  output logic [LEN_W-1:0] bar_len
);
  logic             blank_q;
  logic [LEN_W-1:0] len_nxt;

  led_bounce_phase u_phase (
    .clk     (clk),
    .rst     (rst),
    .blank_q (blank_q)
  );

  led_bounce_stepper #(.LEDS(LEDS), .LEN_W(LEN_W)) u_stepper (
    .clk     (clk),
    .rst     (rst),
    .adv     (~blank_q),
    .len_q   (bar_len),
    .dir_q   (grow),
    .len_nxt (len_nxt)
  );

  led_bounce_shaper #(.LEDS(LEDS), .LEN_W(LEN_W)) u_shaper (
    .clk     (clk),
    .rst     (rst),
    .blank   (blank_q),
    .len_nxt (len_nxt),
    .led_q   (led)
  );

  // R1/R2: reset loads the fixed start state on the next edge
  assert_reset_load_R1: assert property (@(posedge clk)
    rst |=> (led[0] && !led[1] && bar_len == LEN_W'(2) && !grow))
    else $error("reset state not loaded");
  // R3: first cycle out of reset is dark
  assert_strobe_R3: assert property (@(posedge clk)
    ($past(rst) && !rst) |=> (led == '0)) else $error("missing strobe");
endmodule

// File: tb/led_bounce_bar_bench.sv
module led_bounce_bar_bench;
  localparam int PER  = 10;
  localparam int LEDS = 5;
  localparam int LW   = 3;
  localparam int HALF = LEDS - 1;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [LEDS-1:0] led;
  logic          grow;
  logic [LW-1:0] bar_len;

  int checks = 0;
  int fails  = 0;
  int c      = 0;   // cycles since last reset edge
  bit mid    = 0;   // reset applied mid-sequence

  always #(PER/2) clk = ~clk;

  led_bounce_bar u_led_bounce_bar (
    .clk(clk), .rst(rst), .led(led), .grow(grow), .bar_len(bar_len)
  );

  function automatic int frame_len(input int n);
    int m = n % (2*HALF);
    return (m <= HALF) ? m + 1 : 2*LEDS - 1 - m;
  endfunction

  function automatic bit frame_dir(input int n);
    return ((n % (2*HALF)) < HALF);
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s cycle %0d: actual %0h expected %0h", tag, c, act, exp);
    end
  endtask

  task automatic check_now();
    int n;
    int l;
    if (c == 0) begin
      chk(mid ? "R2 led" : "R1 led", led, 5'b10101);
      chk(mid ? "R2 len" : "R1 len", bar_len, 2);
      chk(mid ? "R2 dir" : "R1 dir", grow, 0);
    end else if (c == 1) begin
      chk("R3 strobe", led, 0);
      chk("R7 len", bar_len, 2);
      chk("R6 dir", grow, 0);
    end else begin
      n = (c - 2) / 2;
      l = frame_len(n);
      if (c % 2 == 1) chk("R4 blank", led, 0);
      else if (c == 2) chk("R8 first frame", led, 1);
      else if (l == 2 && frame_len(n-1) == 1) chk("R9 bottom step", led, (1 << l) - 1);
      else chk("R5 frame", led, (1 << l) - 1);
      chk("R7 len", bar_len, l);
      chk("R6 dir", grow, frame_dir(n));
      if (c >= 18 && c % 2 == 0) chk("R8 period", led, (1 << frame_len(n - 8)) - 1);
    end
  endtask

  task automatic cyc(input bit r);
    rst = r;
    @(posedge clk);
    #(PER/4);
    if (r) c = 0; else c = c + 1;
    check_now();
    @(negedge clk);
  endtask

  initial begin
    #(PER*200000);
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    @(negedge clk);
    // R2: held reset keeps the start state
    for (int i = 0; i < 3; i++) begin mid = (i > 0); cyc(1'b1); end
    mid = 0;
    for (int i = 0; i < 60; i++) cyc(1'b0);
    // R2: restart from each phase of the 16-clock period
    for (int p = 0; p < 16; p++) begin
      mid = 1;
      cyc(1'b1);
      mid = 0;
      for (int i = 0; i < 20 + p; i++) cyc(1'b0);
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule